// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-buffer miss in hardware. It accepts a miss carrying a 20-bit virtual page number together with the current root table pointer. It then reads at most two 32-bit table entries from physical memory and produces one of two results. The first is a refill entry for the translation buffer, made of a physical page number, attribute bits and a large-page flag. The second is a page-fault indication that names the table level where the walk stopped.

Table reads use physical addresses only, so the walker never asks for a translation of its own accesses. The memory port is a plain request/response pair. A request is held until the memory accepts it, and the response may come back after any number of cycles. Only one walk is in flight at a time. A first-level entry can map a large page directly, and in that case the second read is skipped.

Each table entry uses this layout: bit 0 means the entry exists, bit 1 means the page is resident, bit 2 marks a leaf (large page), bits 11:3 are attribute bits with bits 5:3 being read, write and dirty, and bits 31:12 hold a page number.

Top module: `ptw_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, miss_ready is 1, and mem_req_valid, refill_valid and fault_valid are all 0.
- R2: The first read of a walk goes to address {root_ppn, vpn[19:10], 2'b00}. Both values are captured in the cycle the miss is accepted.
- R3: A first-level entry with bits 1:0 = 11 and bit 2 = 0 causes a second read at address {entry[31:12], vpn[9:0], 2'b00}.
- R4: An entry at either level with bit 0 = 0 or bit 1 = 0 ends the walk. fault_valid pulses for one cycle with fault_level = 0 for the first level or 1 for the second, and no further read is issued.
- R5: A first-level entry with bits 2:0 = 111 ends the walk after one read. The refill has refill_large = 1, refill_ppn = {entry[31:22], vpn[9:0]} and refill_attr = entry[11:3].
- R6: A present second-level entry gives a refill with refill_large = 0, refill_ppn = entry[31:12] and refill_attr = entry[11:3]. Bit 2 of a second-level entry is ignored.
- R7: miss_ready is 0 from the cycle after a miss is accepted until the cycle after the result pulse. A miss presented meanwhile is not taken, and changing miss_vpn or root_ppn after acceptance has no effect.
- R8: While mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr stays unchanged.
- R9: Any response latency is tolerated. A response that arrives while no read is outstanding has no effect.
- R10: refill_valid and fault_valid are never 1 together, and each lasts exactly one cycle. done_vpn gives the page number of the walk that finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_vpn | input | 20 | Virtual page number of the miss |
| root_ppn | input | 20 | Physical page of the first-level table |
| miss_ready | output | 1 | Walker idle, miss accepted this cycle if valid |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical byte address of the entry |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_data | input | 32 | Table entry read |
| refill_valid | output | 1 | One-cycle refill pulse |
| refill_ppn | output | 20 | Resolved physical page number |
| refill_attr | output | 9 | Attribute bits of the final entry |
| refill_large | output | 1 | Mapping came from a first-level leaf |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_level | output | 1 | 0: first level, 1: second level |
| done_vpn | output | 20 | Page number of the finished walk |

## Verification
The bench walks through a table of walks that covers each way a walk can end: a fault at either level from a missing or a non-resident entry, a large-page exit, and an ordinary two-level hit, all under different response latencies. A walker that kept reading after a fault, or that went to the second level on a large page, shows up as a wrong read count or a wrong address. A walker that took the page number from the wrong bits of a large entry returns the wrong refill_ppn. A second-level entry that sets bit 2 catches a design that trusts the leaf bit at the wrong level. Directed cases hold mem_req_ready low to expose a request whose address drifts, inject a response while idle to expose a walker that reacts to it, and change miss_vpn after acceptance to expose a walker that fails to latch it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // walk controller states, one walk in flight at a time
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walk_state_e;

  // entry flag positions, shared by decoder and checker
  localparam int PTE_EXIST_BIT = 0;
  localparam int PTE_RESID_BIT = 1;
  localparam int PTE_LEAF_BIT  = 2;
  localparam int PTE_ATTR_LSB  = 3;

  // byte address of an entry = base page, index, then this many zero bits
  localparam int ENTRY_BYTES_LG = 2;

  typedef enum logic {
    LVL_FIRST  = 1'b0,
    LVL_SECOND = 1'b1
  } walk_level_e;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PPN_W  = 20,
  parameter int IDX_W  = 10,
  localparam int OFF_W  = IDX_W + ENTRY_BYTES_LG,
  localparam int PTE_W  = PPN_W + OFF_W,
  localparam int ATTR_W = OFF_W - PTE_ATTR_LSB
) (
  input  logic [PTE_W-1:0]  entry,
  output logic              present,
  output logic              leaf,
  output logic [ATTR_W-1:0] attr,
  output logic [PPN_W-1:0]  ppn
);

  // an entry is usable only if it exists and its page is in memory
  always_comb begin
    present = entry[PTE_EXIST_BIT] & entry[PTE_RESID_BIT];
    leaf    = entry[PTE_LEAF_BIT];
    attr    = entry[OFF_W-1:PTE_ATTR_LSB];
    ppn     = entry[PTE_W-1:OFF_W];
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  localparam int PA_W  = PPN_W + IDX_W + ENTRY_BYTES_LG
) (
  input  logic              second,
  input  logic [PPN_W-1:0]  root_base,
  input  logic [PPN_W-1:0]  next_base,
  input  logic [IDX_W-1:0]  idx_first,
  input  logic [IDX_W-1:0]  idx_second,
  output logic [PA_W-1:0]   addr
);

  logic [PPN_W-1:0] base_sel;
  logic [IDX_W-1:0] idx_sel;

  always_comb begin
    base_sel = second ? next_base  : root_base;
    idx_sel  = second ? idx_second : idx_first;
    addr     = {base_sel, idx_sel, {ENTRY_BYTES_LG{1'b0}}};
  end

endmodule

// File: rtl/ptw_result_reg.sv
module ptw_result_reg #(
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_refill,
  input  logic              load_fault,
  input  logic [PPN_W-1:0]  ppn_in,
  input  logic [ATTR_W-1:0] attr_in,
  input  logic              large_in,
  input  logic              level_in,
  output logic [PPN_W-1:0]  ppn_q,
  output logic [ATTR_W-1:0] attr_q,
  output logic              large_q,
  output logic              level_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ppn_q   <= '0;
      attr_q  <= '0;
      large_q <= 1'b0;
      level_q <= 1'b0;
    end else begin
      if (load_refill) begin
        ppn_q   <= ppn_in;
        attr_q  <= attr_in;
        large_q <= large_in;
      end
      if (load_fault) begin
        level_q <= level_in;
      end
    end
  end

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  localparam int VPN_W  = 2 * IDX_W,
  localparam int OFF_W  = IDX_W + ENTRY_BYTES_LG,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int PTE_W  = PA_W,
  localparam int ATTR_W = OFF_W - PTE_ATTR_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              miss_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [PTE_W-1:0]  mem_resp_data,
  output logic              refill_valid,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic [ATTR_W-1:0] refill_attr,
  output logic              refill_large,
  output logic              fault_valid,
  output logic              fault_level,
  output logic [VPN_W-1:0]  done_vpn
);

  walk_state_e state_q, state_d;

  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] root_q;
  logic [PPN_W-1:0] next_base_q;

  logic              ent_present;
  logic              ent_leaf;
  logic [ATTR_W-1:0] ent_attr;
  logic [PPN_W-1:0]  ent_ppn;

  logic              ld_base;
  logic              ld_refill;
  logic              ld_fault;
  logic              res_large;
  walk_level_e       res_level;
  logic [PPN_W-1:0]  res_ppn;

  logic [IDX_W-1:0] idx_first;
  logic [IDX_W-1:0] idx_second;
  logic             accept;

  assign idx_first  = vpn_q[VPN_W-1:IDX_W];
  assign idx_second = vpn_q[IDX_W-1:0];
  assign accept     = miss_valid && (state_q == ST_IDLE);

  // one decoder serves both levels: only one read is outstanding
  ptw_pte_decode #(.PPN_W(PPN_W), .IDX_W(IDX_W)) u_decode (
    .entry   (mem_resp_data),
    .present (ent_present),
    .leaf    (ent_leaf),
    .attr    (ent_attr),
    .ppn     (ent_ppn)
  );

  ptw_addr_gen #(.PPN_W(PPN_W), .IDX_W(IDX_W)) u_addr (
    .second     (state_q == ST_L2_REQ),
    .root_base  (root_q),
    .next_base  (next_base_q),
    .idx_first  (idx_first),
    .idx_second (idx_second),
    .addr       (mem_req_addr)
  );

  // a large page keeps the upper page bits of the entry and
  // takes the low page bits from the second-level index
  always_comb begin
    if (res_large) begin
      res_ppn = {ent_ppn[PPN_W-1:IDX_W], idx_second};
    end else begin
      res_ppn = ent_ppn;
    end
  end

  always_comb begin
    state_d   = state_q;
    ld_base   = 1'b0;
    ld_refill = 1'b0;
    ld_fault  = 1'b0;
    res_large = 1'b0;
    res_level = LVL_FIRST;
    case (state_q)
      ST_IDLE: begin
        if (miss_valid) state_d = ST_L1_REQ;
      end
      ST_L1_REQ: begin
        if (mem_req_ready) state_d = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (mem_resp_valid) begin
          if (!ent_present) begin
            ld_fault  = 1'b1;
            res_level = LVL_FIRST;
            state_d   = ST_FAULT;
          end else if (ent_leaf) begin
            ld_refill = 1'b1;
            res_large = 1'b1;
            state_d   = ST_DONE;
          end else begin
            ld_base   = 1'b1;
            state_d   = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ: begin
        if (mem_req_ready) state_d = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (mem_resp_valid) begin
          if (!ent_present) begin
            ld_fault  = 1'b1;
            res_level = LVL_SECOND;
            state_d   = ST_FAULT;
          end else begin
            ld_refill = 1'b1;
            state_d   = ST_DONE;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      root_q      <= '0;
      next_base_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vpn_q  <= miss_vpn;
        root_q <= root_ppn;
      end
      if (ld_base) begin
        next_base_q <= ent_ppn;
      end
    end
  end

  ptw_result_reg #(.PPN_W(PPN_W), .ATTR_W(ATTR_W)) u_result (
    .clk         (clk),
    .rst         (rst),
    .load_refill (ld_refill),
    .load_fault  (ld_fault),
    .ppn_in      (res_ppn),
    .attr_in     (ent_attr),
    .large_in    (res_large),
    .level_in    (res_level),
    .ppn_q       (refill_ppn),
    .attr_q      (refill_attr),
    .large_q     (refill_large),
    .level_q     (fault_level)
  );

  assign miss_ready    = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign refill_valid  = (state_q == ST_DONE);
  assign fault_valid   = (state_q == ST_FAULT);
  assign done_vpn      = vpn_q;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  localparam int VPN_W = 2 * IDX_W,
  localparam int PA_W  = PPN_W + IDX_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             miss_valid,
  input logic [VPN_W-1:0] miss_vpn,
  input logic [PPN_W-1:0] root_ppn,
  input logic             miss_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_resp_valid,
  input logic             refill_valid,
  input logic             fault_valid
);

  // R1: idle and quiet right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> miss_ready && !mem_req_valid && !refill_valid && !fault_valid);

  // R2: first read targets root page and first index captured at acceptance
  a_r2_first_addr: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=>
      mem_req_valid &&
      (mem_req_addr == {$past(root_ppn), $past(miss_vpn[VPN_W-1:IDX_W]), 2'b00}));

  // R7: busy after acceptance
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);

  // R7: a result pulse is followed by the idle state
  a_r7_idle_after_result: assert property (@(posedge clk) disable iff (rst)
    (refill_valid || fault_valid) |-> !miss_ready ##1 miss_ready);

  // R8: request held while not accepted
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

  // R9: a result is only produced by a response in the previous cycle
  a_r9_result_from_resp: assert property (@(posedge clk) disable iff (rst)
    (refill_valid || fault_valid) |-> $past(mem_resp_valid));

  // R10: exclusive single-cycle result pulses
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(refill_valid && fault_valid));

  a_r10_refill_pulse: assert property (@(posedge clk) disable iff (rst)
    refill_valid |=> !refill_valid);

  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

endmodule

bind ptw_top ptw_checker #(.PPN_W(PPN_W), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .miss_valid     (miss_valid),
  .miss_vpn       (miss_vpn),
  .root_ppn       (root_ppn),
  .miss_ready     (miss_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_resp_valid (mem_resp_valid),
  .refill_valid   (refill_valid),
  .fault_valid    (fault_valid)
);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [19:0] miss_vpn = '0;
  logic [19:0] root_ppn = '0;
  logic        miss_ready;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid;
  logic [31:0] mem_resp_data;
  logic        refill_valid;
  logic [19:0] refill_ppn;
  logic [8:0]  refill_attr;
  logic        refill_large;
  logic        fault_valid;
  logic        fault_level;
  logic [19:0] done_vpn;

  always #2 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_vpn(miss_vpn), .root_ppn(root_ppn),
    .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .refill_valid(refill_valid), .refill_ppn(refill_ppn),
    .refill_attr(refill_attr), .refill_large(refill_large),
    .fault_valid(fault_valid), .fault_level(fault_level),
    .done_vpn(done_vpn)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: one read at a time, fixed latency per walk
  logic [31:0] cur_a1, cur_a2, cur_l1, cur_l2;
  logic [3:0]  cur_lat = '0;
  logic        busy;
  logic [3:0]  cnt;
  logic [31:0] held_addr;
  int          nreq;
  logic [31:0] log_addr [2];
  int          stray_tok = 0;
  int          stray_seen;

  always @(posedge clk) begin
    if (rst) begin
      busy           <= 1'b0;
      cnt            <= '0;
      mem_resp_valid <= 1'b0;
      mem_resp_data  <= '0;
      nreq           <= 0;
      stray_seen     <= stray_tok;
    end else begin
      mem_resp_valid <= 1'b0;
      if (stray_tok != stray_seen) begin
        stray_seen     <= stray_tok;
        mem_resp_valid <= 1'b1;
        mem_resp_data  <= 32'hFFFFF03F;
      end else if (busy) begin
        if (cnt == 0) begin
          mem_resp_valid <= 1'b1;
          mem_resp_data  <= (held_addr == cur_a1) ? cur_l1 :
                            (held_addr == cur_a2) ? cur_l2 : 32'h0;
          busy           <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (mem_req_valid && mem_req_ready) begin
        busy      <= 1'b1;
        cnt       <= cur_lat;
        held_addr <= mem_req_addr;
        log_addr[nreq % 2] <= mem_req_addr;
        nreq      <= nreq + 1;
      end
    end
  end

  typedef struct packed {
    logic [19:0] root;
    logic [19:0] vpn;
    logic [31:0] l1;
    logic [31:0] l2;
    logic [3:0]  lat;
    logic        efault;
    logic        elevel;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{20'h00010, 20'h00403, 32'h00020003, 32'h1234502B, 4'd0, 1'b0, 1'b0}, // two-level hit
    '{20'h00ABC, 20'hFFC01, 32'h8040001F, 32'h00000000, 4'd3, 1'b0, 1'b0}, // large page
    '{20'h00111, 20'h12345, 32'h00030002, 32'h00000000, 4'd1, 1'b1, 1'b0}, // L1 missing
    '{20'h00222, 20'h54321, 32'h00030001, 32'h00000000, 4'd0, 1'b1, 1'b0}, // L1 not resident
    '{20'h00333, 20'h0A5A5, 32'h00040003, 32'h55555039, 4'd2, 1'b1, 1'b1}, // L2 not resident
    '{20'h00444, 20'h3C3C3, 32'h00050003, 32'hABCDE03F, 4'd5, 1'b0, 1'b0}, // L2 leaf bit set
    '{20'h00555, 20'h00001, 32'h00060003, 32'hFFFFF03E, 4'd1, 1'b1, 1'b1}  // L2 missing
  };

  task automatic run_walk(input vec_t v, input int stall);
    logic        l1_ok, l1_leaf, l2_ok;
    logic [31:0] a1, a2;
    int          nbase, nexp, k;
    bit          got;
    a1 = {v.root, v.vpn[19:10], 2'b00};                        // R2
    a2 = {v.l1[31:12], v.vpn[9:0], 2'b00};                     // R3
    l1_ok   = v.l1[0] && v.l1[1];
    l1_leaf = l1_ok && v.l1[2];
    l2_ok   = v.l2[0] && v.l2[1];
    nexp    = (!l1_ok || l1_leaf) ? 1 : 2;
    cur_a1 = a1; cur_a2 = a2; cur_l1 = v.l1; cur_l2 = v.l2; cur_lat = v.lat;
    check(v.efault == (!l1_ok || (!l1_leaf && !l2_ok)), "R4", "table fault flag",
          {31'b0, v.efault}, {31'b0, !l1_ok || (!l1_leaf && !l2_ok)});
    nbase = nreq;
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = v.vpn; root_ppn = v.root;
    mem_req_ready = (stall == 0);
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = ~v.vpn; root_ppn = ~v.root;  // R7: ignored while busy
    check(!miss_ready, "R7", "miss_ready after accept", {31'b0, miss_ready}, 32'h0);
    for (int s = 0; s < stall; s++) begin
      check(mem_req_valid && mem_req_addr == a1, "R8", "held request addr",
            mem_req_addr, a1);
      @(negedge clk);
    end
    mem_req_ready = 1'b1;
    got = 1'b0;
    for (k = 0; k < 200; k++) begin
      if (refill_valid || fault_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    miss_valid = 1'b0;
    check(got, "R9", "walk completes", {31'b0, got}, 32'h1);
    check((nreq - nbase) == nexp, "R4", "number of reads", nreq - nbase, nexp);
    check(log_addr[nbase % 2] == a1, "R2", "first read address",
          log_addr[nbase % 2], a1);
    if (nexp == 2)
      check(log_addr[(nbase + 1) % 2] == a2, "R3", "second read address",
            log_addr[(nbase + 1) % 2], a2);
    check(done_vpn == v.vpn, "R10", "done_vpn", done_vpn, v.vpn);
    check(!(refill_valid && fault_valid), "R10", "exclusive pulses",
          {30'b0, refill_valid, fault_valid}, 32'h0);
    if (v.efault) begin
      check(fault_valid, "R4", "fault pulse", {31'b0, fault_valid}, 32'h1);
      check(fault_level == v.elevel, "R4", "fault level",
            {31'b0, fault_level}, {31'b0, v.elevel});
    end else if (l1_leaf) begin
      check(refill_valid && refill_large, "R5", "large refill",
            {30'b0, refill_valid, refill_large}, 32'h3);
      check(refill_ppn == {v.l1[31:22], v.vpn[9:0]}, "R5", "large ppn",
            refill_ppn, {v.l1[31:22], v.vpn[9:0]});
      check(refill_attr == v.l1[11:3], "R5", "large attr", refill_attr, v.l1[11:3]);
    end else begin
      check(refill_valid && !refill_large, "R6", "small refill",
            {30'b0, refill_valid, refill_large}, 32'h2);
      check(refill_ppn == v.l2[31:12], "R6", "ppn", refill_ppn, v.l2[31:12]);
      check(refill_attr == v.l2[11:3], "R6", "attr", refill_attr, v.l2[11:3]);
    end
    @(negedge clk);
    check(!refill_valid && !fault_valid, "R10", "pulse one cycle",
          {30'b0, refill_valid, fault_valid}, 32'h0);
    check(miss_ready, "R7", "idle after result", {31'b0, miss_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1",
          "state in reset", {28'b0, miss_ready, mem_req_valid, refill_valid, fault_valid},
          32'h8);
    rst = 1'b0;
    @(negedge clk);
    check(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1",
          "state after reset", {28'b0, miss_ready, mem_req_valid, refill_valid, fault_valid},
          32'h8);

    for (int i = 0; i < NV; i++) run_walk(VECS[i], 0);

    // R8: stalled request on first read
    run_walk(VECS[0], 4);
    run_walk(VECS[1], 2);

    // R9: stray response while idle has no effect
    @(negedge clk);
    stray_tok = stray_tok + 1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(!refill_valid && !fault_valid && miss_ready && !mem_req_valid, "R9",
            "stray response ignored",
            {28'b0, miss_ready, mem_req_valid, refill_valid, fault_valid}, 32'h8);
    end
    run_walk(VECS[5], 0);

    // R1: reset in the middle of a walk
    @(negedge clk);
    cur_lat = 4'd9;
    miss_valid = 1'b1; miss_vpn = 20'h00403; root_ppn = 20'h00010;
    @(negedge clk);
    miss_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1",
          "state after mid-walk reset",
          {28'b0, miss_ready, mem_req_valid, refill_valid, fault_valid}, 32'h8);
    run_walk(VECS[4], 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule